// File: doc/BRIEF.md
# Framed Time-Slot Voice Serial Port

This block moves 8-bit voice samples across a framed serial bus that runs on a master bit clock. A frame sync pulse marks where each frame begins. The block works out where one of two 8-bit time slots falls inside that frame. During the chosen slot it shifts a transmit byte out on a serial data line and shifts a receive byte in from a second line. Outside the slot the serial output is released.

The bit clock, frame sync and serial input are sampled by a faster system clock `clk`, and they must already be synchronous to it. Each half period of the bit clock must last at least one `clk` cycle. The block finds the rising and falling bit-clock edges itself and uses them as enables, so all of its state sits in one clock domain.

Control inputs choose how frame sync relates to the first slot, where the second slot sits, which slot is used, whether samples are 8-bit companded codes, and whether transfer is enabled. On the parallel side there is a transmit byte with a load strobe and a receive byte with a one-cycle valid strobe.

Top module: `tslot_voice_port`

## Requirements
- R1: After a synchronous reset, `sdo_oe_o` and `rx_valid_o` are low and `rx_byte_o` is zero.
- R2: With `timing_mode_i` = 2'b00 (direct, normal edges), a frame starts at the bit-clock rising edge where `fsync_i` is first seen high (it was low at the rising edge before). Bit periods are counted from that edge, output bits are launched on rising edges, and input bits are sampled on falling edges.
- R3: With `timing_mode_i` = 2'b01 (direct, swapped edges), a frame starts the same way as in R2, but output bits are launched on falling edges and input bits are sampled on the following rising edge.
- R4: With `timing_mode_i` = 2'b10 or 2'b11 (early sync), `fsync_i` must be seen high at a falling edge where it was low at the falling edge before. The frame then starts at the next rising edge, and the edges are used as in R2.
- R5: Slot B1 covers bit periods 0..7 of the frame. Slot B2 covers periods 8..15 when `gap_format_i`=0, and periods 10..17 when `gap_format_i`=1, which leaves two idle bit periods after B1.
- R6: `slot_b2_i`=1 selects B2 only while `companded_i`=1. When `companded_i`=0 the port always uses B1.
- R7: `sdo_oe_o` is high exactly for the eight launch intervals of the selected slot while `xfer_en_i`=1, and low at all other times. With `xfer_en_i`=0 nothing is driven and no receive strobe is produced.
- R8: The transmit byte goes out MSB first. It is taken from the last `tx_byte_i` loaded by `tx_load_i` at the start of each selected slot, so the same byte is sent again if nothing new was loaded.
- R9: The receive byte is assembled MSB first. `rx_valid_o` pulses high for one `clk` cycle after the eighth bit is sampled, and `rx_byte_o` then holds that byte.
- R10: A frame sync held high for many bit periods does not restart the frame. Only a new low-to-high transition starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_i | input | 1 | Serial bit clock, sampled by `clk` |
| fsync_i | input | 1 | Frame sync |
| sdi_i | input | 1 | Serial receive data |
| timing_mode_i | input | 2 | 00 direct normal, 01 direct swapped edges, 10/11 early sync |
| gap_format_i | input | 1 | 1 places B2 two bit periods after B1 |
| slot_b2_i | input | 1 | 1 selects slot B2 (companded only) |
| companded_i | input | 1 | 1 when samples are 8-bit companded codes |
| xfer_en_i | input | 1 | Enables voice transfer |
| tx_byte_i | input | 8 | Parallel transmit byte |
| tx_load_i | input | 1 | Loads `tx_byte_i` into the transmit holding register |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (low = high impedance) |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new `rx_byte_o` |

## Verification
The bench runs frames over every combination of timing mode, format, slot select, coding and enable, and gives frame sync high times of one bit, two bits and half a frame. In each bit period it checks the serial output against a slot position it computes from arithmetic. A design that counts from the wrong edge, or mishandles early sync, would shift the window by one period. A design that swaps the edges wrongly in the swapped-edge mode would sample receive bits while they are changing and build a wrong byte. A design that ignores the two-bit gap, or honours B2 for linear coding, would drive in the wrong eight periods. A design that restarts on a long sync pulse would drive the slot twice. Odd frames load no new byte, so a design that fails to repeat the held byte is caught.

// File: rtl/tslot_pkg.sv
package tslot_pkg;

    typedef enum logic [1:0] {
        TM_DIRECT_NORM = 2'b00,
        TM_DIRECT_SWAP = 2'b01,
        TM_EARLY       = 2'b10,
        TM_EARLY_ALT   = 2'b11
    } timing_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } clk_edges_t;

    typedef struct packed {
        logic launch;
        logic capture;
    } lane_cue_t;

    function automatic logic swaps_edges(timing_mode_e m);
        return m == TM_DIRECT_SWAP;
    endfunction

    function automatic logic uses_early_sync(timing_mode_e m);
        return (m == TM_EARLY) || (m == TM_EARLY_ALT);
    endfunction

    // Bit period at which the chosen slot begins
    function automatic int unsigned slot_offset(logic use_b2, logic gapped,
                                                int unsigned width, int unsigned gap);
        if (!use_b2) return 0;
        return gapped ? width + gap : width;
    endfunction

endpackage

// File: rtl/tslot_frame_timer.sv
module tslot_frame_timer
    import tslot_pkg::*;
#(
    parameter int POS_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mclk_i,
    input  logic               fsync_i,
    input  timing_mode_e       mode_i,
    output lane_cue_t          cue_o,
    output logic [POS_W-1:0]   launch_pos_o,
    output logic [POS_W-1:0]   capture_pos_o
);
    localparam logic [POS_W-1:0] POS_LAST = '1;

    clk_edges_t       edg;
    logic             mclk_q;
    logic             fs_at_rise;
    logic             fs_at_fall;
    logic             armed;
    logic             start;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;

    assign edg.rise = mclk_i & ~mclk_q;
    assign edg.fall = ~mclk_i & mclk_q;

    always_comb begin
        start = 1'b0;
        if (edg.rise) begin
            if (uses_early_sync(mode_i)) start = armed;
            else                         start = fsync_i & ~fs_at_rise;
        end
        pos_nx = pos_q;
        if (start)                              pos_nx = '0;
        else if (edg.rise && pos_q != POS_LAST) pos_nx = pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mclk_q     <= 1'b0;
            fs_at_rise <= 1'b0;
            fs_at_fall <= 1'b0;
            armed      <= 1'b0;
            pos_q      <= POS_LAST;
        end else begin
            mclk_q <= mclk_i;
            pos_q  <= pos_nx;
            if (edg.rise) begin
                fs_at_rise <= fsync_i;
                armed      <= 1'b0;
            end
            if (edg.fall) begin
                fs_at_fall <= fsync_i;
                armed      <= uses_early_sync(mode_i) & fsync_i & ~fs_at_fall;
            end
        end
    end

    assign cue_o.launch   = swaps_edges(mode_i) ? edg.fall : edg.rise;
    assign cue_o.capture  = swaps_edges(mode_i) ? edg.rise : edg.fall;
    assign launch_pos_o   = swaps_edges(mode_i) ? pos_q : pos_nx;
    assign capture_pos_o  = pos_q;

    AST_EARLY_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (start && uses_early_sync(mode_i)) |-> fs_at_fall); // R4

endmodule

// File: rtl/tslot_tx_lane.sv
module tslot_tx_lane #(
    parameter int W     = 8,
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] first_i,
    input  logic             enable_i,
    input  logic [W-1:0]     tx_byte_i,
    input  logic             tx_load_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);
    localparam logic [POS_W:0] SPAN = (POS_W+1)'(W);

    logic [W-1:0]   hold_q;
    logic [W-1:0]   shift_q;
    logic [POS_W:0] rel;
    logic           hit;
    logic [POS_W:0] sent_cnt;

    assign rel = {1'b0, pos_i} - {1'b0, first_i};
    assign hit = (pos_i >= first_i) && (rel < SPAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            shift_q  <= '0;
            sdo_o    <= 1'b0;
            sdo_oe_o <= 1'b0;
            sent_cnt <= '0;
        end else begin
            if (tx_load_i) hold_q <= tx_byte_i;
            if (launch_i) begin
                if (enable_i && hit) begin
                    sdo_oe_o <= 1'b1;
                    sent_cnt <= sent_cnt + 1'b1;
                    if (rel == '0) begin
                        sdo_o   <= hold_q[W-1];
                        shift_q <= {hold_q[W-2:0], 1'b0};
                    end else begin
                        sdo_o   <= shift_q[W-1];
                        shift_q <= {shift_q[W-2:0], 1'b0};
                    end
                end else begin
                    sdo_oe_o <= 1'b0;
                    sent_cnt <= '0;
                end
            end
        end
    end

    AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        sent_cnt <= SPAN); // R7
    AST_TX_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
        (launch_i && !enable_i) |=> !sdo_oe_o); // R7

endmodule

// File: rtl/tslot_rx_lane.sv
module tslot_rx_lane #(
    parameter int W     = 8,
    parameter int POS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic [POS_W-1:0] first_i,
    input  logic             enable_i,
    input  logic             sdi_i,
    output logic [W-1:0]     rx_byte_o,
    output logic             rx_valid_o
);
    localparam logic [POS_W:0] SPAN = (POS_W+1)'(W);

    logic [W-1:0]   shift_q;
    logic [W-1:0]   shift_nx;
    logic [POS_W:0] rel;
    logic           hit;

    assign rel      = {1'b0, pos_i} - {1'b0, first_i};
    assign hit      = (pos_i >= first_i) && (rel < SPAN);
    assign shift_nx = {shift_q[W-2:0], sdi_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q    <= '0;
            rx_byte_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            if (capture_i && enable_i && hit) begin
                shift_q <= shift_nx;
                if (rel == SPAN - 1'b1) begin
                    rx_byte_o  <= shift_nx;
                    rx_valid_o <= 1'b1;
                end
            end
        end
    end

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o); // R9
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |=> $stable(rx_byte_o) || rx_valid_o); // R9

endmodule

// File: rtl/tslot_voice_port.sv
module tslot_voice_port
    import tslot_pkg::*;
#(
    parameter int W     = 8,
    parameter int GAP   = 2,
    parameter int POS_W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mclk_i,
    input  logic         fsync_i,
    input  logic         sdi_i,
    input  logic [1:0]   timing_mode_i,
    input  logic         gap_format_i,
    input  logic         slot_b2_i,
    input  logic         companded_i,
    input  logic         xfer_en_i,
    input  logic [W-1:0] tx_byte_i,
    input  logic         tx_load_i,
    output logic         sdo_o,
    output logic         sdo_oe_o,
    output logic [W-1:0] rx_byte_o,
    output logic         rx_valid_o
);
    lane_cue_t        cue;
    logic [POS_W-1:0] launch_pos;
    logic [POS_W-1:0] capture_pos;
    logic [POS_W-1:0] first_pos;

    assign first_pos = POS_W'(slot_offset(companded_i & slot_b2_i, gap_format_i, W, GAP));

    tslot_frame_timer #(.POS_W(POS_W)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .mclk_i        (mclk_i),
        .fsync_i       (fsync_i),
        .mode_i        (timing_mode_e'(timing_mode_i)),
        .cue_o         (cue),
        .launch_pos_o  (launch_pos),
        .capture_pos_o (capture_pos)
    );

    tslot_tx_lane #(.W(W), .POS_W(POS_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .launch_i  (cue.launch),
        .pos_i     (launch_pos),
        .first_i   (first_pos),
        .enable_i  (xfer_en_i),
        .tx_byte_i (tx_byte_i),
        .tx_load_i (tx_load_i),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    tslot_rx_lane #(.W(W), .POS_W(POS_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .capture_i  (cue.capture),
        .pos_i      (capture_pos),
        .first_i    (first_pos),
        .enable_i   (xfer_en_i),
        .sdi_i      (sdi_i),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );

    AST_LINEAR_USES_B1: assert property (@(posedge clk) disable iff (rst)
        (!companded_i && cue.launch && launch_pos >= POS_W'(W) && $past(!companded_i)) |=> !sdo_oe_o); // R6

endmodule

// File: tb/tslot_voice_port_bench.sv
module tslot_voice_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk = 1'b0, fs = 1'b0, sdi = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       fmt = 1'b0, b2 = 1'b0, cmp = 1'b0, en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_load = 1'b0;
    logic       sdo, sdo_oe, rx_valid;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int rx_count = 0;
    logic [7:0] last_rx = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    tslot_voice_port u_tslot_voice_port (
        .clk(clk), .rst(rst), .mclk_i(mclk), .fsync_i(fs), .sdi_i(sdi),
        .timing_mode_i(mode), .gap_format_i(fmt), .slot_b2_i(b2),
        .companded_i(cmp), .xfer_en_i(en), .tx_byte_i(tx_byte),
        .tx_load_i(tx_load), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid) begin
            rx_count <= rx_count + 1;
            last_rx  <= rx_byte;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic lvl, input logic fs_v, input logic sdi_v);
        @(negedge clk);
        mclk = lvl; fs = fs_v; sdi = sdi_v;
        @(negedge clk);
    endtask

    task automatic check_out(input string tag, input bit active, input int bitpos, input logic [7:0] txe);
        chk(sdo_oe == active, {tag, " R5 R6 R7 oe"}, int'(sdo_oe), int'(active));
        if (active)
            chk(sdo == txe[7-bitpos], {tag, " R8 data"}, int'(sdo), int'(txe[7-bitpos]));
    endtask

    task automatic run_frame(input int m, input bit f, input bit s2, input bit c, input bit e,
                             input logic [7:0] rxb, input int fs_len, input logic [7:0] txe);
        bit    rev, dly;
        int    first, rxc0;
        logic  cur;
        string tag;
        mode = 2'(m); fmt = f; b2 = s2; cmp = c; en = e;
        rev = (m == 1);
        dly = (m >= 2);
        tag = rev ? "R3" : (dly ? "R4" : "R2");
        if (fs_len > 2) tag = {tag, " R10"};
        first = (c && s2) ? (f ? 10 : 8) : 0;
        cur = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0);
        end
        rxc0 = rx_count;
        if (dly) begin
            step(1'b1, 1'b1, 1'b0);
            step(1'b0, 1'b1, 1'b0);
        end
        for (int p = 0; p < 20; p++) begin
            bit   fsv, ins;
            logic b;
            fsv = dly ? (p < fs_len - 1) : (p < fs_len);
            ins = (p >= first) && (p < first + 8);
            b   = ins ? rxb[7-(p-first)] : 1'b0;
            if (!rev) cur = b;
            step(1'b1, fsv, cur);
            if (!rev) check_out(tag, e && ins, p - first, txe);
            if (rev) cur = b;
            step(1'b0, fsv, cur);
            if (rev) check_out(tag, e && ins, p - first, txe);
        end
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        if (e) begin
            chk(rx_count == rxc0 + 1, {tag, " R9 rx count"}, rx_count - rxc0, 1);
            chk(last_rx == rxb, {tag, " R9 rx byte"}, int'(last_rx), int'(rxb));
        end else begin
            chk(rx_count == rxc0, "R7 no rx when disabled", rx_count - rxc0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] held;
        int idx;
        held = 8'h00;
        idx  = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sdo_oe == 1'b0, "R1 oe after reset", int'(sdo_oe), 0);
        chk(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);
        chk(rx_byte == 8'h00, "R1 rx byte after reset", int'(rx_byte), 0);
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 2; f++)
                for (int s2 = 0; s2 < 2; s2++)
                    for (int c = 0; c < 2; c++)
                        for (int e = 0; e < 2; e++) begin
                            int fl;
                            logic [7:0] rxb;
                            if (idx % 2 == 0) begin
                                held = 8'(8'h5A ^ (idx * 37));
                                @(negedge clk);
                                tx_byte = held; tx_load = 1'b1;
                                @(negedge clk);
                                tx_load = 1'b0;
                                tx_byte = ~held;
                            end
                            fl  = (idx % 3 == 0) ? 1 : ((idx % 3 == 1) ? 2 : 10);
                            rxb = 8'(idx * 53 + 17);
                            run_frame(m, f[0], s2[0], c[0], e[0], rxb, fl, held);
                            idx++;
                        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule